// File: doc/BRIEF.md
# UART FIFO Ready and Flow-Control Status

This block generates the per-channel handshake pins of a UART whose receive and transmit FIFOs each hold 64 bytes. It takes the occupancy counts of both FIFOs, two programmable thresholds, a receive-error flag, event pulses from the receive side and a few control bits. From these it drives three active-low outputs: a receive-ready pin, a transmit-ready pin and a request-to-send pin. The FIFO storage, the baud generator and the shift registers are in other blocks. This block sees them only through counts and pulses.

The two ready pins have hysteresis because different conditions set and release them. Receive-ready goes low once the receive FIFO reaches its threshold, or once received data has waited too long below it. It goes back high only when the FIFO drains to empty or holds an error. Transmit-ready goes low once there is enough free space in the transmit FIFO and goes high only when that FIFO is full. Request-to-send is either driven straight from a control bit or throttled automatically by the receive fill level. The block also includes a small inactivity timer counted in character times, and the local-loopback multiplexer for the serial lines.

Top module: `uart_fifo_flow`

## Requirements
- R1: While `rst` is high, at the next clock edge `rxRdyN`, `txRdyN`, `rtsN`, `txPin` and `rxSerOut` all become 1.
- R2: One clock after an edge where `rxCount` is nonzero, `rxErr` is 0 and `rxCount >= rxTrig`, `rxRdyN` is 0.
- R3: One clock after an edge where `rxCount == 0` or `rxErr == 1`, `rxRdyN` is 1. This release takes priority over any set condition.
- R4: When neither the R2 condition, the R3 condition nor a timeout holds, `rxRdyN` keeps its previous value.
- R5: Free space is 64 minus `txCount`. One clock after an edge where `txCount == 64`, `txRdyN` is 1. Otherwise, if free space `>= txTrig`, `txRdyN` is 0 one clock later. In all other cases it holds.
- R6: With `autoRtsEn` = 0, `rtsN` equals the inverse of `rtsManual` one clock later.
- R7: With `autoRtsEn` = 1, `rtsN` is 1 one clock later if `rtsManual` is 0 or `rxCount >= rxTrig`. Otherwise it is 0.
- R8: The timer is armed while `0 < rxCount < rxTrig`. It counts `charTick` pulses. A pulse on `rxPush` or `rxPop`, or losing the armed condition, clears the count. On the edge that registers the fourth uninterrupted pulse, the timer reaches its limit, and `rxRdyN` goes to 0 at the following edge.
- R9: With `loopEn` = 1, `rxSerOut` follows `txSerIn` and `txPin` is 1, both one clock later. With `loopEn` = 0, `rxSerOut` follows `rxPin` and `txPin` follows `txSerIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxCount | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rxTrig | input | 7 | Receive threshold |
| txCount | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| txTrig | input | 7 | Transmit free-space threshold |
| rxErr | input | 1 | An errored byte is held in the receive FIFO |
| rxPush | input | 1 | Pulse: byte written into the receive FIFO |
| rxPop | input | 1 | Pulse: byte read from the receive FIFO |
| charTick | input | 1 | Pulse: one character time elapsed |
| rtsManual | input | 1 | Control bit: request to send |
| autoRtsEn | input | 1 | Select automatic request-to-send |
| loopEn | input | 1 | Local loopback enable |
| txSerIn | input | 1 | Serial stream from the transmit shifter |
| rxPin | input | 1 | External serial receive line, idles high |
| rxRdyN | output | 1 | Receive ready, active low |
| txRdyN | output | 1 | Transmit ready, active low |
| rtsN | output | 1 | Request to send, active low |
| txPin | output | 1 | External serial transmit line |
| rxSerOut | output | 1 | Serial stream to the receive shifter |

## Verification
Every output is registered. Each result therefore appears at the edge after the inputs that cause it: the bench drives on the falling edge, lets one rising edge pass, and samples on the next falling edge. The timeout path adds one stage, because the timer reaches its limit on the edge that takes the fourth tick and the pin moves on the edge after that. The bench checks that the pin is still high after the fourth-tick edge and low one edge later. Hysteresis cases are placed in sequence in the vector table, so each held value is checked against the state left by the row before it.

// File: rtl/uart_fifo_flow_pkg.sv
package uart_fifo_flow_pkg;
  typedef struct packed {
    logic rxSet;
    logic rxClr;
    logic txSet;
    logic txClr;
    logic rtsLow;
    logic tmoClr;
    logic tmoStep;
  } flowStrobes_t;
endpackage

// File: rtl/uart_fifo_flow_ctrl.sv
module uart_fifo_flow_ctrl
  import uart_fifo_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] rxTrig,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] txTrig,
  input  logic          rxErr,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          charTick,
  input  logic          rtsManual,
  input  logic          autoRtsEn,
  input  logic          tmoHit,
  output flowStrobes_t  strobes
);
  logic [CW-1:0] txFree;
  logic rxAtTrig;
  logic armed;

  always_comb begin
    txFree   = CW'(DEPTH) - txCount;
    rxAtTrig = (rxCount >= rxTrig);
    armed    = (rxCount != '0) && !rxAtTrig;

    strobes.rxClr   = (rxCount == '0) || rxErr;
    strobes.rxSet   = rxAtTrig || (tmoHit && armed);
    strobes.txClr   = (txCount == CW'(DEPTH));
    strobes.txSet   = (txFree >= txTrig);
    strobes.rtsLow  = autoRtsEn ? (rtsManual && !rxAtTrig) : rtsManual;
    strobes.tmoClr  = rxPush || rxPop || !armed;
    strobes.tmoStep = charTick && armed;
  end
endmodule

// File: rtl/uart_fifo_flow_dp.sv
module uart_fifo_flow_dp
  import uart_fifo_flow_pkg::*;
#(
  parameter int TMO_CHARS = 4,
  localparam int TW = $clog2(TMO_CHARS + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  flowStrobes_t strobes,
  input  logic         loopEn,
  input  logic         txSerIn,
  input  logic         rxPin,
  output logic         tmoHit,
  output logic         rxRdyN,
  output logic         txRdyN,
  output logic         rtsN,
  output logic         txPin,
  output logic         rxSerOut
);
  logic [TW-1:0] tmoCnt;

  assign tmoHit = (tmoCnt == TW'(TMO_CHARS));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmoCnt   <= '0;
      rxRdyN   <= 1'b1;
      txRdyN   <= 1'b1;
      rtsN     <= 1'b1;
      txPin    <= 1'b1;
      rxSerOut <= 1'b1;
    end else begin
      if (strobes.tmoClr)
        tmoCnt <= '0;
      else if (strobes.tmoStep && !tmoHit)
        tmoCnt <= tmoCnt + 1'b1;

      if (strobes.rxClr)      rxRdyN <= 1'b1;
      else if (strobes.rxSet) rxRdyN <= 1'b0;

      if (strobes.txClr)      txRdyN <= 1'b1;
      else if (strobes.txSet) txRdyN <= 1'b0;

      rtsN     <= !strobes.rtsLow;
      txPin    <= loopEn ? 1'b1 : txSerIn;
      rxSerOut <= loopEn ? txSerIn : rxPin;
    end
  end
endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow
  import uart_fifo_flow_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TMO_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] rxTrig,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] txTrig,
  input  logic          rxErr,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          charTick,
  input  logic          rtsManual,
  input  logic          autoRtsEn,
  input  logic          loopEn,
  input  logic          txSerIn,
  input  logic          rxPin,
  output logic          rxRdyN,
  output logic          txRdyN,
  output logic          rtsN,
  output logic          txPin,
  output logic          rxSerOut
);
  flowStrobes_t strobes;
  logic tmoHit;

  uart_fifo_flow_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .rxCount(rxCount), .rxTrig(rxTrig), .txCount(txCount), .txTrig(txTrig),
    .rxErr(rxErr), .rxPush(rxPush), .rxPop(rxPop), .charTick(charTick),
    .rtsManual(rtsManual), .autoRtsEn(autoRtsEn), .tmoHit(tmoHit),
    .strobes(strobes)
  );

  uart_fifo_flow_dp #(.TMO_CHARS(TMO_CHARS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .loopEn(loopEn),
    .txSerIn(txSerIn), .rxPin(rxPin), .tmoHit(tmoHit),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN), .rtsN(rtsN),
    .txPin(txPin), .rxSerOut(rxSerOut)
  );
endmodule

// File: rtl/uart_fifo_flow_chk.sv
module uart_fifo_flow_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] rxCount,
  input logic [CW-1:0] rxTrig,
  input logic [CW-1:0] txCount,
  input logic          rxErr,
  input logic          rtsManual,
  input logic          autoRtsEn,
  input logic          loopEn,
  input logic          txSerIn,
  input logic          rxPin,
  input logic          rxRdyN,
  input logic          txRdyN,
  input logic          rtsN,
  input logic          txPin,
  input logic          rxSerOut
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (rxRdyN && txRdyN && rtsN && txPin && rxSerOut));

  assert_rx_set_R2: assert property (@(posedge clk) disable iff (rst)
    (rxCount != '0 && !rxErr && rxCount >= rxTrig) |=> !rxRdyN);

  assert_rx_release_R3: assert property (@(posedge clk) disable iff (rst)
    (rxCount == '0 || rxErr) |=> rxRdyN);

  assert_tx_full_R5: assert property (@(posedge clk) disable iff (rst)
    (txCount == CW'(DEPTH)) |=> txRdyN);

  assert_rts_manual_R6: assert property (@(posedge clk) disable iff (rst)
    !autoRtsEn |=> (rtsN == !$past(rtsManual)));

  assert_rts_auto_R7: assert property (@(posedge clk) disable iff (rst)
    (autoRtsEn && rxCount >= rxTrig) |=> rtsN);

  assert_loop_tx_idle_R9: assert property (@(posedge clk) disable iff (rst)
    loopEn |=> txPin);

  assert_loop_path_R9: assert property (@(posedge clk) disable iff (rst)
    loopEn |=> (rxSerOut == $past(txSerIn)));

  assert_normal_path_R9: assert property (@(posedge clk) disable iff (rst)
    !loopEn |=> (rxSerOut == $past(rxPin) && txPin == $past(txSerIn)));
endmodule

bind uart_fifo_flow uart_fifo_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rxCount(rxCount), .rxTrig(rxTrig), .txCount(txCount),
  .rxErr(rxErr), .rtsManual(rtsManual), .autoRtsEn(autoRtsEn), .loopEn(loopEn),
  .txSerIn(txSerIn), .rxPin(rxPin), .rxRdyN(rxRdyN), .txRdyN(txRdyN),
  .rtsN(rtsN), .txPin(txPin), .rxSerOut(rxSerOut)
);

// File: tb/uart_fifo_flow_tb.sv
module uart_fifo_flow_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] rxCount = '0, rxTrig = 7'd8, txCount = '0, txTrig = 7'd16;
  logic rxErr = 0, rxPush = 0, rxPop = 0, charTick = 0;
  logic rtsManual = 0, autoRtsEn = 0, loopEn = 0, txSerIn = 1, rxPin = 1;
  logic rxRdyN, txRdyN, rtsN, txPin, rxSerOut;
  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_fifo_flow u_dut (
    .clk(clk), .rst(rst), .rxCount(rxCount), .rxTrig(rxTrig),
    .txCount(txCount), .txTrig(txTrig), .rxErr(rxErr), .rxPush(rxPush),
    .rxPop(rxPop), .charTick(charTick), .rtsManual(rtsManual),
    .autoRtsEn(autoRtsEn), .loopEn(loopEn), .txSerIn(txSerIn), .rxPin(rxPin),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN), .rtsN(rtsN), .txPin(txPin),
    .rxSerOut(rxSerOut)
  );

  // row: rxCount, rxTrig, txCount, txTrig, rxErr, rtsManual, autoRtsEn,
  //      loopEn, txSerIn, rxPin | exp rxRdyN, txRdyN, rtsN, txPin, rxSerOut
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {7'd0,  7'd8,  7'd0,  7'd16, 6'b000010, 5'b10110},
    {7'd8,  7'd8,  7'd50, 7'd16, 6'b010001, 5'b00001},
    {7'd3,  7'd8,  7'd64, 7'd16, 6'b011101, 5'b01010},
    {7'd10, 7'd8,  7'd60, 7'd16, 6'b011110, 5'b01111},
    {7'd10, 7'd8,  7'd48, 7'd16, 6'b101011, 5'b10111},
    {7'd5,  7'd8,  7'd48, 7'd16, 6'b011000, 5'b10000},
    {7'd1,  7'd1,  7'd63, 7'd1,  6'b000011, 5'b00111},
    {7'd64, 7'd32, 7'd64, 7'd16, 6'b011000, 5'b01100}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      charTick = 1'b1;
      step();
      charTick = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    check("R1 rxRdyN", rxRdyN, 1'b1);
    check("R1 txRdyN", txRdyN, 1'b1);
    check("R1 rtsN", rtsN, 1'b1);
    check("R1 txPin", txPin, 1'b1);
    check("R1 rxSerOut", rxSerOut, 1'b1);
    rst = 1'b0;

    // vector table: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      {rxCount, rxTrig, txCount, txTrig} = VEC[v][38:11];
      {rxErr, rtsManual, autoRtsEn, loopEn, txSerIn, rxPin} = VEC[v][10:5];
      step();
      check("R2/R3/R4 rxRdyN", rxRdyN, VEC[v][4]);
      check("R5 txRdyN", txRdyN, VEC[v][3]);
      check("R6/R7 rtsN", rtsN, VEC[v][2]);
      check("R9 txPin", txPin, VEC[v][1]);
      check("R9 rxSerOut", rxSerOut, VEC[v][0]);
    end

    // R8: timeout, cleared by push
    rxErr = 0; loopEn = 0; rxTrig = 7'd8; rxCount = 7'd0;
    step();
    check("R3 empty release", rxRdyN, 1'b1);
    rxCount = 7'd3;
    step();
    ticks(3);
    check("R8 three ticks no fire", rxRdyN, 1'b1);
    rxPush = 1'b1; step(); rxPush = 1'b0;
    ticks(3);
    check("R8 push clears timer", rxRdyN, 1'b1);
    ticks(1);
    check("R8 limit reached, pin next edge", rxRdyN, 1'b1);
    step();
    check("R8 timeout asserts", rxRdyN, 1'b0);
    step();
    check("R4 hold after timeout", rxRdyN, 1'b0);

    // R8: cleared by pop
    rxCount = 7'd0; step();
    check("R3 empty release again", rxRdyN, 1'b1);
    rxCount = 7'd3; step();
    ticks(2);
    rxPop = 1'b1; step(); rxPop = 1'b0;
    ticks(3);
    check("R8 pop clears timer", rxRdyN, 1'b1);
    ticks(1); step();
    check("R8 timeout after pop", rxRdyN, 1'b0);

    // R3 priority: error with count above trigger
    rxCount = 7'd20; rxErr = 1'b1; step();
    check("R3 error beats set", rxRdyN, 1'b1);

    // R1 again: reset from active state
    rxErr = 1'b0; rtsManual = 1'b1; autoRtsEn = 1'b0; txCount = 7'd0;
    step();
    check("R6 manual low", rtsN, 1'b0);
    rst = 1'b1; step();
    check("R1 rtsN after reset", rtsN, 1'b1);
    check("R1 rxRdyN after reset", rxRdyN, 1'b1);
    check("R1 txRdyN after reset", txRdyN, 1'b1);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule